// File: doc/BRIEF.md
# Configurable-Frame UART Transmitter

This block turns queued characters into an asynchronous serial bit stream. A host writes 9-bit words into a small holding FIFO. A framing engine takes each word and sends it on a single output line. When nothing is being sent, the line rests high.

The engine runs on a baud tick that pulses at sixteen times the bit rate. A control word selects the character shape: how many data bits, how many stop bits, and which parity scheme. The control word also has a 9-bit framing switch and a break switch. The 9-bit switch overrides the length and parity choices. The break switch pulls the line low.

The shape is captured when a character starts, so the host may change the control word at any time without damaging a character already on the line. Two status outputs report an empty FIFO and an idle engine.

Top module: `uart_frame_tx`

## Requirements
- R1: After synchronous reset, tx_out is high, fifo_empty is 1 and tx_idle is 1.
- R2: A frame is a low start bit, then the data bits least significant first, then the optional parity bit, then high stop time. Every start, data and parity bit lasts 16 baud ticks. The line is high whenever no frame is in progress.
- R3: Outside 9-bit mode, len_sel codes 00, 01, 10 and 11 give 5, 6, 7 and 8 data bits. Only the low bits of wr_data are sent.
- R4: stop_sel = 0 gives 16 ticks of stop time. stop_sel = 1 gives 24 ticks for 5-bit characters and 32 ticks for every other length, 9-bit included.
- R5: par_sel works as follows. If bit 0 is 0, no parity bit is sent. Code 001 gives odd parity (the data plus the parity bit hold an odd number of ones). Code 011 gives even parity. Code 101 forces the parity bit to 1. Code 111 forces it to 0.
- R6: With nine_bit = 1, all 9 bits of the word are sent and no parity bit is added. len_sel and par_sel have no effect.
- R7: On every baud tick while brk_force is 1, tx_out is driven low. No new character leaves the FIFO while brk_force is 1, and queued words are not lost. A frame already in progress keeps its timing, hidden under the break. Sending resumes once brk_force falls.
- R8: The FIFO holds 16 words. A write while it is full is dropped. fifo_empty is 1 exactly when the FIFO holds no word.
- R9: tx_idle falls on the tick that starts a character. It rises on the tick after the last stop tick if no word is ready. If a word is ready at that point, its start bit follows the stop time directly and tx_idle stays low.
- R10: The frame settings are sampled when a character starts. Later changes to len_sel, stop_sel, par_sel or nine_bit apply from the next character on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| baud_tick | input | 1 | Enable pulse at 16x the bit rate |
| len_sel | input | 2 | Data length code |
| stop_sel | input | 1 | Stop time select |
| par_sel | input | 3 | Parity mode code |
| brk_force | input | 1 | Hold the line low |
| nine_bit | input | 1 | 9-bit framing mode |
| wr_en | input | 1 | FIFO write strobe |
| wr_data | input | 9 | Word to queue |
| tx_out | output | 1 | Serial line |
| fifo_empty | output | 1 | FIFO holds no word |
| tx_idle | output | 1 | No frame in progress |

## Verification
Several actions can fall on the same baud tick.

The first pair is the end of one character's stop time and the loading of the next character from the FIFO. The bench provokes this by queueing several words back to back, and separately by releasing break while words wait. It then judges whether the start bit follows the last stop tick with no high gap, and whether tx_idle stays low across the join.

A host write can also land in the same cycle that the engine pops the head word, including when the FIFO is full. The bench covers this with a behavioural model built on a queue, which decides acceptance from the occupancy before the pop.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

    localparam int WORD_W = 9;

    typedef enum logic [2:0] {
        ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP
    } tx_state_e;

    // Order matches par_sel[2:1].
    typedef enum logic [1:0] {
        PM_ODD, PM_EVEN, PM_ONE, PM_ZERO
    } par_mode_e;

    typedef enum logic [1:0] {
        SP_ONE, SP_ONE_HALF, SP_TWO
    } stop_mode_e;

    typedef struct packed {
        logic [3:0] nbits;
        logic       par_en;
        par_mode_e  par_mode;
        stop_mode_e stop_mode;
    } frame_cfg_t;

    function automatic frame_cfg_t decode_frame(
        input logic [1:0] len_sel,
        input logic       stop_sel,
        input logic [2:0] par_sel,
        input logic       nine_bit
    );
        frame_cfg_t c;
        if (nine_bit) begin
            c.nbits    = 4'd9;
            c.par_en   = 1'b0;
            c.par_mode = PM_ODD;
        end else begin
            c.nbits    = {2'b00, len_sel} + 4'd5;
            c.par_en   = par_sel[0];
            c.par_mode = par_mode_e'(par_sel[2:1]);
        end
        if (!stop_sel)
            c.stop_mode = SP_ONE;
        else if (!nine_bit && len_sel == 2'b00)
            c.stop_mode = SP_ONE_HALF;
        else
            c.stop_mode = SP_TWO;
        return c;
    endfunction

    function automatic logic calc_parity(
        input logic [WORD_W-1:0] d,
        input logic [3:0]        nbits,
        input par_mode_e         mode
    );
        logic x;
        x = 1'b0;
        for (int i = 0; i < WORD_W; i++)
            if (i < int'(nbits)) x = x ^ d[i];
        case (mode)
            PM_ODD:  return ~x;
            PM_EVEN: return x;
            PM_ONE:  return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/uart_tx_fifo.sv
module uart_tx_fifo #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_en,
    output logic [WIDTH-1:0] rd_data,
    output logic             empty,
    output logic             full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wptr, rptr;
    logic [CW-1:0]    count;
    logic             wr_ok, rd_ok;

    assign empty   = (count == '0);
    assign full    = (count == CW'(DEPTH));
    assign wr_ok   = wr_en && !full;
    assign rd_ok   = rd_en && !empty;
    assign rd_data = mem[rptr];

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (wr_ok) mem[wptr] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (wr_ok) wptr <= bump(wptr);
            if (rd_ok) rptr <= bump(rptr);
            case ({wr_ok, rd_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/uart_tx_framer.sv
module uart_tx_framer
    import uart_tx_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              brk,
    input  frame_cfg_t        cfg_in,
    input  logic              src_empty,
    input  logic [WORD_W-1:0] src_data,
    output logic              pop,
    output logic              line_out,
    output logic              idle
);
    localparam int CW = $clog2(2 * OVS);
    localparam logic [CW-1:0] BIT_LAST  = CW'(OVS - 1);
    localparam logic [CW-1:0] STOP_1    = CW'(OVS - 1);
    localparam logic [CW-1:0] STOP_1H   = CW'(OVS + OVS / 2 - 1);
    localparam logic [CW-1:0] STOP_2    = CW'(2 * OVS - 1);

    tx_state_e         state_q, state_n;
    logic [CW-1:0]     cnt_q, cnt_n;
    logic [3:0]        idx_q, idx_n;
    logic [WORD_W-1:0] sh_q, sh_n;
    frame_cfg_t        cfg_q, cfg_n;
    logic              par_q, par_n;
    logic              line_q, line_n;
    logic              out_q, out_n;
    logic              can_load;

    function automatic logic [CW-1:0] stop_len(input stop_mode_e m);
        case (m)
            SP_ONE_HALF: return STOP_1H;
            SP_TWO:      return STOP_2;
            default:     return STOP_1;
        endcase
    endfunction

    assign can_load = !src_empty && !brk;

    always_comb begin
        state_n = state_q;
        cnt_n   = cnt_q;
        idx_n   = idx_q;
        sh_n    = sh_q;
        cfg_n   = cfg_q;
        par_n   = par_q;
        line_n  = line_q;
        out_n   = out_q;
        pop     = 1'b0;
        if (tick) begin
            if (state_q == ST_IDLE || (state_q == ST_STOP && cnt_q == '0)) begin
                if (can_load) begin
                    pop     = 1'b1;
                    cfg_n   = cfg_in;
                    sh_n    = src_data;
                    par_n   = calc_parity(src_data, cfg_in.nbits, cfg_in.par_mode);
                    idx_n   = '0;
                    cnt_n   = BIT_LAST;
                    line_n  = 1'b0;
                    state_n = ST_START;
                end else begin
                    line_n  = 1'b1;
                    state_n = ST_IDLE;
                end
            end else if (cnt_q != '0) begin
                cnt_n = cnt_q - 1'b1;
            end else begin
                case (state_q)
                    ST_START: begin
                        state_n = ST_DATA;
                        cnt_n   = BIT_LAST;
                        line_n  = sh_q[0];
                    end
                    ST_DATA: begin
                        if (idx_q == cfg_q.nbits - 4'd1) begin
                            if (cfg_q.par_en) begin
                                state_n = ST_PAR;
                                cnt_n   = BIT_LAST;
                                line_n  = par_q;
                            end else begin
                                state_n = ST_STOP;
                                cnt_n   = stop_len(cfg_q.stop_mode);
                                line_n  = 1'b1;
                            end
                        end else begin
                            idx_n  = idx_q + 4'd1;
                            sh_n   = sh_q >> 1;
                            line_n = sh_q[1];
                            cnt_n  = BIT_LAST;
                        end
                    end
                    ST_PAR: begin
                        state_n = ST_STOP;
                        cnt_n   = stop_len(cfg_q.stop_mode);
                        line_n  = 1'b1;
                    end
                    default: begin
                        state_n = ST_IDLE;
                        line_n  = 1'b1;
                    end
                endcase
            end
            out_n = brk ? 1'b0 : line_n;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            idx_q   <= '0;
            sh_q    <= '0;
            cfg_q   <= '0;
            par_q   <= 1'b0;
            line_q  <= 1'b1;
            out_q   <= 1'b1;
        end else begin
            state_q <= state_n;
            cnt_q   <= cnt_n;
            idx_q   <= idx_n;
            sh_q    <= sh_n;
            cfg_q   <= cfg_n;
            par_q   <= par_n;
            line_q  <= line_n;
            out_q   <= out_n;
        end
    end

    assign line_out = out_q;
    assign idle     = (state_q == ST_IDLE);
endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx
    import uart_tx_pkg::*;
#(
    parameter int FIFO_DEPTH = 16,
    parameter int OVS        = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              baud_tick,
    input  logic [1:0]        len_sel,
    input  logic              stop_sel,
    input  logic [2:0]        par_sel,
    input  logic              brk_force,
    input  logic              nine_bit,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    output logic              tx_out,
    output logic              fifo_empty,
    output logic              tx_idle
);
    frame_cfg_t        cfg;
    logic              fifo_pop, fifo_full;
    logic [WORD_W-1:0] head;

    assign cfg = decode_frame(len_sel, stop_sel, par_sel, nine_bit);

    uart_tx_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(WORD_W)) i_fifo (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .rd_en   (fifo_pop),
        .rd_data (head),
        .empty   (fifo_empty),
        .full    (fifo_full)
    );

    uart_tx_framer #(.OVS(OVS)) i_framer (
        .clk       (clk),
        .rst       (rst),
        .tick      (baud_tick),
        .brk       (brk_force),
        .cfg_in    (cfg),
        .src_empty (fifo_empty),
        .src_data  (head),
        .pop       (fifo_pop),
        .line_out  (tx_out),
        .idle      (tx_idle)
    );
endmodule

// File: rtl/uart_frame_tx_chk.sv
module uart_frame_tx_chk (
    input logic clk,
    input logic rst,
    input logic baud_tick,
    input logic brk_force,
    input logic tx_out,
    input logic fifo_empty,
    input logic tx_idle,
    input logic fifo_full,
    input logic fifo_pop
);
    // R7
    break_low_chk: assert property (@(posedge clk) disable iff (rst)
        brk_force && baud_tick |=> !tx_out);

    // R7
    break_no_start_chk: assert property (@(posedge clk) disable iff (rst)
        tx_idle && brk_force |=> tx_idle);

    // R2
    idle_high_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_idle) && !$past(brk_force) |-> tx_out);

    // R9
    start_low_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(tx_idle) |-> !tx_out && $past(!fifo_empty));

    // R8
    full_hold_chk: assert property (@(posedge clk) disable iff (rst)
        fifo_full && !fifo_pop |=> fifo_full);

    // R8
    no_pop_empty_chk: assert property (@(posedge clk) disable iff (rst)
        fifo_empty |-> !fifo_pop);
endmodule

bind uart_frame_tx uart_frame_tx_chk i_chk (
    .clk        (clk),
    .rst        (rst),
    .baud_tick  (baud_tick),
    .brk_force  (brk_force),
    .tx_out     (tx_out),
    .fifo_empty (fifo_empty),
    .tx_idle    (tx_idle),
    .fifo_full  (fifo_full),
    .fifo_pop   (fifo_pop)
);

// File: tb/test_uart_frame_tx.sv
module test_uart_frame_tx;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       baud_tick = 1'b0;
    logic [1:0] len_sel = 2'b11;
    logic       stop_sel = 1'b0;
    logic [2:0] par_sel = 3'b000;
    logic       brk_force = 1'b0;
    logic       nine_bit = 1'b0;
    logic       wr_en = 1'b0;
    logic [8:0] wr_data = '0;
    logic       tx_out, fifo_empty, tx_idle;

    int    n_chk = 0, n_err = 0;
    string cur_req = "R1";
    bit    run_cmp = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    uart_frame_tx i_uart_frame_tx (
        .clk(clk), .rst(rst), .baud_tick(baud_tick), .len_sel(len_sel),
        .stop_sel(stop_sel), .par_sel(par_sel), .brk_force(brk_force),
        .nine_bit(nine_bit), .wr_en(wr_en), .wr_data(wr_data),
        .tx_out(tx_out), .fifo_empty(fifo_empty), .tx_idle(tx_idle)
    );

    // Reference model
    int unsigned mq[$];
    bit          lvl[$];
    bit          m_out = 1'b1, m_idle = 1'b1;

    task automatic build(input int unsigned w);
        int nb, stop_t, ones;
        bit pen, pb;
        if (nine_bit) begin nb = 9; pen = 0; end
        else begin nb = 5 + len_sel; pen = par_sel[0]; end
        if (!stop_sel) stop_t = 16;
        else if (!nine_bit && len_sel == 2'b00) stop_t = 24;
        else stop_t = 32;
        ones = 0;
        for (int i = 0; i < nb; i++) ones += w[i];
        case (par_sel[2:1])
            2'b00: pb = (ones % 2 == 0);
            2'b01: pb = (ones % 2 == 1);
            2'b10: pb = 1;
            default: pb = 0;
        endcase
        for (int i = 0; i < 16; i++) lvl.push_back(1'b0);
        for (int b = 0; b < nb; b++)
            for (int i = 0; i < 16; i++) lvl.push_back(w[b]);
        if (pen) for (int i = 0; i < 16; i++) lvl.push_back(pb);
        for (int i = 0; i < stop_t; i++) lvl.push_back(1'b1);
    endtask

    always @(posedge clk) begin
        if (rst) begin
            mq.delete(); lvl.delete(); m_out = 1; m_idle = 1;
        end else begin
            int  pre;
            bit  ld, lv;
            pre = mq.size();
            ld  = 0;
            if (baud_tick) begin
                if (lvl.size() == 0) begin
                    if (pre > 0 && !brk_force) begin
                        build(mq[0]); ld = 1; m_idle = 0;
                    end else m_idle = 1;
                end
                lv = (lvl.size() > 0) ? lvl.pop_front() : 1'b1;
                m_out = brk_force ? 1'b0 : lv;
            end
            if (ld) void'(mq.pop_front());
            if (wr_en && pre < 16) mq.push_back(int'(wr_data));
        end
    end

    task automatic chk(input logic act, input logic exp, input string req, input string what);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual %0b expected %0b at %0t", req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) baud_tick <= ~baud_tick;

    always @(negedge clk) begin
        if (run_cmp && !rst) begin
            chk(tx_out, m_out, cur_req, "tx_out");
            chk(fifo_empty, mq.size() == 0, cur_req, "fifo_empty");
            chk(tx_idle, m_idle, cur_req, "tx_idle");
        end
    end

    task automatic send(input logic [8:0] w);
        @(negedge clk); wr_en = 1; wr_data = w;
        @(negedge clk); wr_en = 0;
    endtask

    task automatic drain;
        do @(negedge clk); while (!(m_idle && mq.size() == 0 && lvl.size() == 0));
        repeat (4) @(negedge clk);
    endtask

    task automatic finish_run;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        chk(tx_out, 1'b1, "R1", "tx_out");
        chk(fifo_empty, 1'b1, "R1", "fifo_empty");
        chk(tx_idle, 1'b1, "R1", "tx_idle");
        run_cmp = 1;

        // R2 / R3: each length code, 1 stop, no parity
        cur_req = "R2";
        send(9'h0A5); drain();
        cur_req = "R3";
        for (int l = 0; l < 4; l++) begin
            len_sel = 2'(l); send(9'h1B6 ^ 9'(l * 37)); drain();
        end

        // R5: parity modes on 7-bit characters
        cur_req = "R5";
        len_sel = 2'b10;
        foreach (par_sel_list[k]) begin
            par_sel = par_sel_list[k];
            send(9'h05B); drain();
            send(9'h05A); drain();
        end
        par_sel = 3'b000;

        // R4: stop time for 5-bit and 8-bit
        cur_req = "R4";
        stop_sel = 1; len_sel = 2'b00; send(9'h013); drain();
        len_sel = 2'b11; send(9'h0C3); drain();
        stop_sel = 0;

        // R6: 9-bit mode, length/parity fields set to odd values
        cur_req = "R6";
        nine_bit = 1; len_sel = 2'b00; par_sel = 3'b011;
        send(9'h1A3); drain();
        stop_sel = 1; send(9'h155); drain();
        nine_bit = 0; stop_sel = 0; par_sel = 3'b000; len_sel = 2'b11;

        // R9: back-to-back characters
        cur_req = "R9";
        send(9'h011); send(9'h0EE); send(9'h07F); drain();

        // R10: settings changed mid-character
        cur_req = "R10";
        par_sel = 3'b011; send(9'h0F0);
        repeat (100) @(negedge clk);
        len_sel = 2'b00; par_sel = 3'b000; stop_sel = 1;
        drain();
        len_sel = 2'b11; stop_sel = 0;

        // R7: break in the middle of a frame, with words queued
        cur_req = "R7";
        send(9'h0AA);
        repeat (60) @(negedge clk);
        brk_force = 1;
        send(9'h0CC); send(9'h033);
        repeat (500) @(negedge clk);
        chk(tx_out, 1'b0, "R7", "tx_out in break");
        chk(tx_idle, 1'b1, "R7", "tx_idle in break");
        chk(fifo_empty, 1'b0, "R7", "fifo kept in break");
        brk_force = 0;
        drain();

        // R8: overfill while break stalls the engine
        cur_req = "R8";
        brk_force = 1;
        for (int i = 0; i < 18; i++) send(9'(i * 29 + 3));
        chk(fifo_empty, 1'b0, "R8", "fifo_empty after fill");
        brk_force = 0;
        drain();
        chk(fifo_empty, 1'b1, "R8", "fifo_empty after drain");

        finish_run();
    end

    logic [2:0] par_sel_list [4] = '{3'b001, 3'b011, 3'b101, 3'b111};
endmodule